// File: doc/BRIEF.md
# Flash Controller Command and Interrupt Register Block

This block holds the command, controller-status, interrupt-status and two system-configuration registers of a NAND-style flash controller. Software reaches them over a plain 16-bit register bus with a small select field. A command write that is accepted becomes a one-cycle start pulse, carrying the 8-bit opcode, toward a separate array engine. The engine later reports completion with an operation kind and an error flag. The block folds those reports into the status and interrupt registers and drives an interrupt pin, whose polarity software selects, and a ready pin.

Two reset flavours exist. The synchronous active-low reset input loads the cold values. Writing one of the two reset opcodes loads the warm values, which differ only in the interrupt-status word. While the master interrupt flag is set, command writes are locked out. Software acknowledges an event by writing a mask that is ANDed into the interrupt register. Dropping the master flag this way also wipes the error bits.

Top module: `flash_irq_regs`

## Requirements
- R1: After the reset input is held low for a clock edge, configuration 1 holds 0x40C0, configuration 2, status and command hold 0, interrupt status holds 0x8080, and the ready and interrupt pins are 1.
- R2: An accepted command write of opcode 0xF0 or 0xF3 restores the R1 values except that interrupt status becomes 0x8010. It produces no start pulse, and it overrides any completion report in the same cycle.
- R3: A command write while interrupt-status bit 15 is 1 is ignored: no start pulse, and the command register keeps its old value.
- R4: A write to interrupt status stores the old value AND the written value. If bit 15 of that result is 0, status bits 13, 12, 11 and 10 are cleared.
- R5: The interrupt pin is interrupt-status bit 15 when configuration-1 bit 6 is 1, and its inverse when bit 6 is 0. It follows register changes without extra delay.
- R6: The ready pin takes configuration-1 bit 7 on each configuration-1 write, and is 1 after either reset.
- R7: A completion report (done high for one cycle) sets interrupt bit 15 plus a kind bit. Kind code 0 (load) sets bit 7, code 1 (program, copy-back) sets bit 6, code 2 (erase) sets bit 5, and code 3 (other) sets no extra bit.
- R8: A completion report with the error flag also sets status bit 10, plus bit 13 for load, bit 12 for program or bit 11 for erase. The other kind sets only bit 10.
- R9: An accepted command write with an opcode outside the set {0x00, 0x13, 0x80, 0x1A, 0x1B, 0x23, 0x27, 0x2A, 0x2C, 0x30, 0x65, 0x71, 0x94, 0x95, 0xB0, 0xF0, 0xF3} sets status bit 10 and interrupt bit 15, and produces no start pulse. The command register still stores the value.
- R10: Reading configuration 1 returns its stored value with bits 4 to 0 forced to 0.
- R11: An accepted write of a recognised, non-reset opcode raises the start output for exactly the following cycle, with the opcode output equal to bits 7 to 0 of the written value.
- R12: When an interrupt-status write and a completion report fall in the same cycle, the AND is applied first and the completion bits are set on top of the result.
- R13: Register select codes are 0 command, 1 configuration 1, 2 configuration 2, 3 status (read-only) and 4 interrupt status. Read data is combinational. Other selects read 0, and writes to them or to status change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low cold reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_sel_i | input | 3 | Register select |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for the selected register |
| eng_start_o | output | 1 | One-cycle start pulse to the array engine |
| eng_op_o | output | 8 | Opcode accompanying the start pulse |
| eng_done_i | input | 1 | Completion report from the engine |
| eng_kind_i | input | 2 | Completion kind: 0 load, 1 program, 2 erase, 3 other |
| eng_err_i | input | 1 | Completion ended in error |
| irq_o | output | 1 | Interrupt pin, polarity from configuration-1 bit 6 |
| ready_o | output | 1 | Ready pin |

## Verification
The bench targets the command lockout. A design that ignored the master flag would emit a start pulse and overwrite the command register while an event is still pending. The acknowledge path is checked with masks that keep bit 15 and with masks that drop it. A design that assigned instead of ANDing, or that cleared the error bits on every acknowledge, shows wrong status words. Same-cycle collisions are also exercised: acknowledge against completion, and reset opcode against completion. Either mistake in ordering drops or keeps flags that should not survive. Both pin polarities, the read masking of configuration 1 and unknown opcodes are also covered, and the bench mixes them with seeded random traffic.

// File: rtl/flash_irq_pkg.sv
// Package: shared constants, bit positions, select codes and opcode
// classification for the flash command/interrupt register block.
package flash_irq_pkg;

    localparam int DATA_W = 16;
    localparam int SEL_W  = 3;
    localparam int OP_W   = 8;

    // Interrupt-status bit positions
    localparam int INT_MASTER = 15;
    localparam int INT_LOAD   = 7;
    localparam int INT_PROG   = 6;
    localparam int INT_ERASE  = 5;
    localparam int INT_RESET  = 4;

    // Status bit positions
    localparam int ERR_CMD   = 10;
    localparam int ERR_ERASE = 11;
    localparam int ERR_PROG  = 12;
    localparam int ERR_LOAD  = 13;

    // Configuration-1 bit positions
    localparam int CFG1_IRQ_POL = 6;
    localparam int CFG1_RDY     = 7;
    localparam int CFG1_RD_LOW  = 5;   // number of low bits read as zero

    localparam logic [DATA_W-1:0] ERR_MASK  = (DATA_W'(1) << ERR_CMD)  |
                                              (DATA_W'(1) << ERR_ERASE)|
                                              (DATA_W'(1) << ERR_PROG) |
                                              (DATA_W'(1) << ERR_LOAD);
    localparam logic [DATA_W-1:0] CFG1_INIT = 16'h40C0;
    localparam logic [DATA_W-1:0] CFG2_INIT = 16'h0000;
    localparam logic [DATA_W-1:0] INT_COLD  = 16'h8080;
    localparam logic [DATA_W-1:0] INT_WARM  = 16'h8010;

    typedef enum logic [SEL_W-1:0] {
        SEL_CMD  = 3'd0,
        SEL_CFG1 = 3'd1,
        SEL_CFG2 = 3'd2,
        SEL_STAT = 3'd3,
        SEL_INT  = 3'd4
    } reg_sel_e;

    typedef enum logic [1:0] {
        KIND_LOAD  = 2'd0,
        KIND_PROG  = 2'd1,
        KIND_ERASE = 2'd2,
        KIND_OTHER = 2'd3
    } done_kind_e;

    // Number of completion kinds that carry their own flag bits
    localparam int N_FLAG_KINDS = 3;

    // Opcodes that restart the register block with warm values
    function automatic logic op_is_reset(input logic [OP_W-1:0] op);
        return (op == 8'hF0) || (op == 8'hF3);
    endfunction

    // Opcodes forwarded to the array engine
    function automatic logic op_is_engine(input logic [OP_W-1:0] op);
        case (op)
            8'h00, 8'h13, 8'h80, 8'h1A, 8'h1B,
            8'h23, 8'h27, 8'h2A, 8'h2C, 8'h30,
            8'h65, 8'h71, 8'h94, 8'h95, 8'hB0: return 1'b1;
            default:                           return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/flash_irq_cmd_dec.sv
// Module: command-write decoder.
// Classifies a command write into accepted-for-engine, warm-reset or
// unknown, taking the lockout from the master interrupt flag into account.
// Assumes at most one bus write per cycle; purely combinational.
module flash_irq_cmd_dec
    import flash_irq_pkg::*;
(
    input  logic            wr_cmd_i,
    input  logic            locked_i,
    input  logic [OP_W-1:0] op_i,
    output logic            take_o,
    output logic            start_o,
    output logic            warm_o,
    output logic            bad_o
);

    logic is_rst;
    logic is_eng;

    // Opcode classification
    always_comb begin
        is_rst = op_is_reset(op_i);
        is_eng = op_is_engine(op_i);
    end

    // Gate classification with the write strobe and lockout
    always_comb begin
        take_o  = wr_cmd_i && !locked_i;
        start_o = take_o && is_eng;
        warm_o  = take_o && is_rst;
        bad_o   = take_o && !is_eng && !is_rst;
    end

endmodule

// File: rtl/flash_irq_evt_map.sv
// Module: completion-event mapper.
// Turns one completion report into set-masks for the interrupt-status
// and controller-status registers. Assumes done is a one-cycle pulse.
module flash_irq_evt_map
    import flash_irq_pkg::*;
(
    input  logic              done_i,
    input  logic [1:0]        kind_i,
    input  logic              err_i,
    output logic [DATA_W-1:0] int_set_o,
    output logic [DATA_W-1:0] stat_set_o
);

    localparam int INT_POS [N_FLAG_KINDS] = '{INT_LOAD, INT_PROG, INT_ERASE};
    localparam int ERR_POS [N_FLAG_KINDS] = '{ERR_LOAD, ERR_PROG, ERR_ERASE};

    logic [N_FLAG_KINDS-1:0] hit;

    // One match line per kind that owns flag bits
    for (genvar k = 0; k < N_FLAG_KINDS; k++) begin : g_kind
        assign hit[k] = done_i && (kind_i == 2'(k));
    end

    // Assemble the set-masks
    always_comb begin
        int_set_o  = '0;
        stat_set_o = '0;
        if (done_i) begin
            int_set_o[INT_MASTER] = 1'b1;
            if (err_i) stat_set_o[ERR_CMD] = 1'b1;
        end
        for (int k = 0; k < N_FLAG_KINDS; k++) begin
            if (hit[k]) begin
                int_set_o[INT_POS[k]] = 1'b1;
                if (err_i) stat_set_o[ERR_POS[k]] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/flash_irq_pins.sv
// Module: interrupt and ready pin drivers.
// The interrupt pin is combinational from the master flag and the
// polarity bit; the ready pin is a flop loaded on configuration writes.
// Synchronous active-low reset.
module flash_irq_pins (
    input  logic clk,
    input  logic rst_n,
    input  logic warm_i,
    input  logic cfg_wr_i,
    input  logic rdy_bit_i,
    input  logic master_i,
    input  logic pol_high_i,
    output logic irq_o,
    output logic ready_o
);

    logic rdy_q;

    // Ready flop: high after any reset, loaded on configuration writes
    always_ff @(posedge clk) begin
        if (!rst_n || warm_i) rdy_q <= 1'b1;
        else if (cfg_wr_i)    rdy_q <= rdy_bit_i;
    end

    // Interrupt pin with selectable polarity
    always_comb begin
        irq_o   = pol_high_i ? master_i : !master_i;
        ready_o = rdy_q;
    end

endmodule

// File: rtl/flash_irq_rdmux.sv
// Module: register read multiplexer.
// Combinational read path; configuration 1 has its low bits masked.
// Unused selects return zero.
module flash_irq_rdmux
    import flash_irq_pkg::*;
(
    input  logic [SEL_W-1:0]  sel_i,
    input  logic [DATA_W-1:0] cmd_i,
    input  logic [DATA_W-1:0] cfg1_i,
    input  logic [DATA_W-1:0] cfg2_i,
    input  logic [DATA_W-1:0] stat_i,
    input  logic [DATA_W-1:0] int_i,
    output logic [DATA_W-1:0] rdata_o
);

    localparam logic [DATA_W-1:0] CFG1_RD_MASK = ~((DATA_W'(1) << CFG1_RD_LOW) - 1'b1);

    // Select the addressed register
    always_comb begin
        case (sel_i)
            SEL_CMD:  rdata_o = cmd_i;
            SEL_CFG1: rdata_o = cfg1_i & CFG1_RD_MASK;
            SEL_CFG2: rdata_o = cfg2_i;
            SEL_STAT: rdata_o = stat_i;
            SEL_INT:  rdata_o = int_i;
            default:  rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/flash_irq_regs.sv
// Module: top of the flash command/interrupt register block.
// Holds command, configuration, status and interrupt-status registers,
// launches engine commands, merges completion reports, drives pins.
// Assumes a single-cycle register bus and one-cycle done pulses.
// Synchronous active-low reset loads cold values.
module flash_irq_regs
    import flash_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_i,
    input  logic [SEL_W-1:0]  bus_sel_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              eng_start_o,
    output logic [OP_W-1:0]   eng_op_o,
    input  logic              eng_done_i,
    input  logic [1:0]        eng_kind_i,
    input  logic              eng_err_i,
    output logic              irq_o,
    output logic              ready_o
);

    logic [DATA_W-1:0] cmd_q, cfg1_q, cfg2_q, stat_q, int_q;
    logic              start_q;
    logic [OP_W-1:0]   op_q;

    logic wr_cmd, wr_cfg1, wr_cfg2, wr_int;
    logic take, start, warm, bad;
    logic [DATA_W-1:0] int_set, stat_set;
    logic [DATA_W-1:0] int_acked, stat_acked;
    logic [DATA_W-1:0] int_nxt, stat_nxt;

    // Write strobes per register
    always_comb begin
        wr_cmd  = bus_wr_i && (bus_sel_i == SEL_CMD);
        wr_cfg1 = bus_wr_i && (bus_sel_i == SEL_CFG1);
        wr_cfg2 = bus_wr_i && (bus_sel_i == SEL_CFG2);
        wr_int  = bus_wr_i && (bus_sel_i == SEL_INT);
    end

    flash_irq_cmd_dec u_dec (
        .wr_cmd_i (wr_cmd),
        .locked_i (int_q[INT_MASTER]),
        .op_i     (bus_wdata_i[OP_W-1:0]),
        .take_o   (take),
        .start_o  (start),
        .warm_o   (warm),
        .bad_o    (bad)
    );

    flash_irq_evt_map u_evt (
        .done_i     (eng_done_i),
        .kind_i     (eng_kind_i),
        .err_i      (eng_err_i),
        .int_set_o  (int_set),
        .stat_set_o (stat_set)
    );

    // Acknowledge first, then OR in new events
    always_comb begin
        int_acked  = wr_int ? (int_q & bus_wdata_i) : int_q;
        stat_acked = (wr_int && !int_acked[INT_MASTER]) ? (stat_q & ~ERR_MASK) : stat_q;
        int_nxt    = int_acked | int_set;
        stat_nxt   = stat_acked | stat_set;
        if (bad) begin
            int_nxt[INT_MASTER] = 1'b1;
            stat_nxt[ERR_CMD]   = 1'b1;
        end
    end

    // Register file with cold and warm reset values
    always_ff @(posedge clk) begin
        if (!rst_n || warm) begin
            cmd_q  <= '0;
            cfg1_q <= CFG1_INIT;
            cfg2_q <= CFG2_INIT;
            stat_q <= '0;
            int_q  <= !rst_n ? INT_COLD : INT_WARM;
        end else begin
            if (take)    cmd_q  <= bus_wdata_i;
            if (wr_cfg1) cfg1_q <= bus_wdata_i;
            if (wr_cfg2) cfg2_q <= bus_wdata_i;
            int_q  <= int_nxt;
            stat_q <= stat_nxt;
        end
    end

    // Engine launch pulse and opcode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            op_q    <= '0;
        end else begin
            start_q <= start;
            if (start) op_q <= bus_wdata_i[OP_W-1:0];
        end
    end

    assign eng_start_o = start_q;
    assign eng_op_o    = op_q;

    flash_irq_pins u_pins (
        .clk        (clk),
        .rst_n      (rst_n),
        .warm_i     (warm),
        .cfg_wr_i   (wr_cfg1),
        .rdy_bit_i  (bus_wdata_i[CFG1_RDY]),
        .master_i   (int_q[INT_MASTER]),
        .pol_high_i (cfg1_q[CFG1_IRQ_POL]),
        .irq_o      (irq_o),
        .ready_o    (ready_o)
    );

    flash_irq_rdmux u_rd (
        .sel_i   (bus_sel_i),
        .cmd_i   (cmd_q),
        .cfg1_i  (cfg1_q),
        .cfg2_i  (cfg2_q),
        .stat_i  (stat_q),
        .int_i   (int_q),
        .rdata_o (bus_rdata_o)
    );

endmodule

// File: rtl/flash_irq_regs_chk.sv
// Module: assertion checker for flash_irq_regs, attached by bind.
// Observes ports and the held register state.
module flash_irq_regs_chk
    import flash_irq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr_i,
    input logic [SEL_W-1:0]  bus_sel_i,
    input logic [DATA_W-1:0] bus_wdata_i,
    input logic [DATA_W-1:0] bus_rdata_o,
    input logic              eng_start_o,
    input logic [OP_W-1:0]   eng_op_o,
    input logic              eng_done_i,
    input logic              eng_err_i,
    input logic              irq_o,
    input logic              ready_o,
    input logic [DATA_W-1:0] int_q,
    input logic [DATA_W-1:0] stat_q,
    input logic [DATA_W-1:0] cfg1_q,
    input logic [DATA_W-1:0] cmd_q
);

    // R3: locked command write changes nothing
    p_cmd_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr_i && bus_sel_i == SEL_CMD && int_q[INT_MASTER]
        |=> !eng_start_o && cmd_q == $past(cmd_q));

    // R4: acknowledge is an AND
    p_int_and_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr_i && bus_sel_i == SEL_INT && !eng_done_i
        |=> int_q == $past(int_q & bus_wdata_i));

    // R4: dropping the master flag wipes errors
    p_err_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr_i && bus_sel_i == SEL_INT && !eng_done_i
        && !(int_q[INT_MASTER] && bus_wdata_i[INT_MASTER])
        |=> (stat_q & ERR_MASK) == '0);

    // R5: active-high polarity
    p_irq_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg1_q[CFG1_IRQ_POL] |-> irq_o == int_q[INT_MASTER]);

    // R5: active-low polarity
    p_irq_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg1_q[CFG1_IRQ_POL] |-> irq_o != int_q[INT_MASTER]);

    // R6: ready follows configuration writes
    p_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr_i && bus_sel_i == SEL_CFG1 |=> ready_o == $past(bus_wdata_i[CFG1_RDY]));

    // R7: completion raises the master flag
    p_done_master_r7: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done_i && !bus_wr_i |=> int_q[INT_MASTER]);

    // R8: failed completion raises command error
    p_done_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done_i && eng_err_i && !bus_wr_i |=> stat_q[ERR_CMD]);

    // R10: configuration-1 readback low bits are zero
    p_cfg_rd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel_i == SEL_CFG1 |-> bus_rdata_o[CFG1_RD_LOW-1:0] == '0);

    // R11: accepted load opcode launches next cycle
    p_start_op_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr_i && bus_sel_i == SEL_CMD && !int_q[INT_MASTER] && bus_wdata_i[OP_W-1:0] == 8'h00
        |=> eng_start_o && eng_op_o == 8'h00);

endmodule

bind flash_irq_regs flash_irq_regs_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr_i    (bus_wr_i),
    .bus_sel_i   (bus_sel_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .eng_start_o (eng_start_o),
    .eng_op_o    (eng_op_o),
    .eng_done_i  (eng_done_i),
    .eng_err_i   (eng_err_i),
    .irq_o       (irq_o),
    .ready_o     (ready_o),
    .int_q       (int_q),
    .stat_q      (stat_q),
    .cfg1_q      (cfg1_q),
    .cmd_q       (cmd_q)
);

// File: tb/flash_irq_regs_tb.sv
// Bench: directed corner cases plus seeded random traffic, checked
// against a reference model built from the requirements.
module flash_irq_regs_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_sel = 3'd0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        eng_start;
    logic [7:0]  eng_op;
    logic        eng_done = 1'b0;
    logic [1:0]  eng_kind = 2'd0;
    logic        eng_err = 1'b0;
    logic        irq, ready;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    // Reference state
    logic [15:0] m_cmd, m_cfg1, m_cfg2, m_stat, m_int;
    logic        m_rdy, m_start;
    logic [7:0]  m_op;

    always #4 clk = ~clk;

    flash_irq_regs dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr_i    (bus_wr),
        .bus_sel_i   (bus_sel),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .eng_start_o (eng_start),
        .eng_op_o    (eng_op),
        .eng_done_i  (eng_done),
        .eng_kind_i  (eng_kind),
        .eng_err_i   (eng_err),
        .irq_o       (irq),
        .ready_o     (ready)
    );

    function automatic bit known_op(input logic [7:0] op);
        return op inside {8'h00, 8'h13, 8'h80, 8'h1A, 8'h1B, 8'h23, 8'h27,
                          8'h2A, 8'h2C, 8'h30, 8'h65, 8'h71, 8'h94, 8'h95, 8'hB0};
    endfunction

    function automatic logic [15:0] rd_model(input logic [2:0] sel);
        case (sel)
            3'd0: return m_cmd;
            3'd1: return m_cfg1 & 16'hFFE0;
            3'd2: return m_cfg2;
            3'd3: return m_stat;
            3'd4: return m_int;
            default: return 16'h0;
        endcase
    endfunction

    function automatic void model_reset(input bit cold);
        m_cmd = 0; m_cfg1 = 16'h40C0; m_cfg2 = 0; m_stat = 0;
        m_int = cold ? 16'h8080 : 16'h8010;
        m_rdy = 1'b1;
    endfunction

    // One clock of model behaviour
    function automatic void model_step(input bit wr, input logic [2:0] sel,
                                       input logic [15:0] d, input bit dn,
                                       input logic [1:0] k, input bit er);
        bit warm = 0;
        bit bad = 0;
        m_start = 0;
        if (wr && sel == 3'd0 && !m_int[15]) begin
            if (d[7:0] == 8'hF0 || d[7:0] == 8'hF3) warm = 1;
            else begin
                m_cmd = d;
                if (known_op(d[7:0])) begin m_start = 1; m_op = d[7:0]; end
                else bad = 1;
            end
        end
        if (warm) begin model_reset(0); return; end
        if (wr && sel == 3'd1) begin m_cfg1 = d; m_rdy = d[7]; end
        if (wr && sel == 3'd2) m_cfg2 = d;
        if (wr && sel == 3'd4) begin
            m_int = m_int & d;
            if (!m_int[15]) m_stat = m_stat & ~16'h3C00;
        end
        if (dn) begin
            m_int[15] = 1;
            case (k)
                2'd0: m_int[7] = 1;
                2'd1: m_int[6] = 1;
                2'd2: m_int[5] = 1;
                default: ;
            endcase
            if (er) begin
                m_stat[10] = 1;
                case (k)
                    2'd0: m_stat[13] = 1;
                    2'd1: m_stat[12] = 1;
                    2'd2: m_stat[11] = 1;
                    default: ;
                endcase
            end
        end
        if (bad) begin m_int[15] = 1; m_stat[10] = 1; end
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one cycle, then compare all outputs after the edge
    task automatic step(input string req, input bit wr, input logic [2:0] sel,
                        input logic [15:0] d, input bit dn = 0,
                        input logic [1:0] k = 0, input bit er = 0);
        @(negedge clk);
        bus_wr = wr; bus_sel = sel; bus_wdata = d;
        eng_done = dn; eng_kind = k; eng_err = er;
        model_step(wr, sel, d, dn, k, er);
        @(posedge clk);
        #2;
        check({req, " rdata"}, bus_rdata, rd_model(sel));
        check({req, " start"}, 16'(eng_start), 16'(m_start));
        if (m_start) check({req, " op"}, 16'(eng_op), 16'(m_op));
        check({req, " ready"}, 16'(ready), 16'(m_rdy));
        check({req, " irq"}, 16'(irq), 16'(m_cfg1[6] ? m_int[15] : !m_int[15]));
    endtask

    task automatic rd(input string req, input logic [2:0] sel);
        step(req, 0, sel, 16'h0);
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        model_reset(1);
        m_start = 0; m_op = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: cold reset values
        for (int s = 0; s < 8; s++) rd("R1 cold reset", 3'(s));

        // R4/R5: acknowledge all, pin goes low (active high)
        step("R4 ack", 1, 3'd4, 16'h0000);
        rd("R4 status after ack", 3'd3);
        // R11: load launch
        step("R11 load launch", 1, 3'd0, 16'h1200);
        rd("R11 pulse ends", 3'd0);
        // R7: load done
        step("R7 load done", 0, 3'd4, 16'h0, 1, 2'd0, 0);
        // R3: locked command write
        step("R3 locked write", 1, 3'd0, 16'h0080);
        rd("R3 cmd unchanged", 3'd0);
        // R8: program error on top
        step("R8 prog err", 0, 3'd3, 16'h0, 1, 2'd1, 1);
        // R4: ack keeping master keeps errors, then drop master
        step("R4 keep master", 1, 3'd4, 16'h8000);
        rd("R4 errors kept", 3'd3);
        step("R4 drop master", 1, 3'd4, 16'h7FFF);
        rd("R4 errors cleared", 3'd3);
        rd("R4 low bits kept", 3'd4);
        step("R4 clear rest", 1, 3'd4, 16'h0000);
        // R9: unknown opcode
        step("R9 unknown op", 1, 3'd0, 16'h0042);
        rd("R9 status", 3'd3);
        rd("R9 cmd stored", 3'd0);
        step("R9 ack", 1, 3'd4, 16'h0000);
        // R8: erase and other errors
        step("R8 erase err", 0, 3'd3, 16'h0, 1, 2'd2, 1);
        step("R8 ack", 1, 3'd4, 16'h0000);
        step("R7 other done", 0, 3'd4, 16'h0, 1, 2'd3, 1);
        rd("R8 other err", 3'd3);
        // R12: ack and done together
        step("R12 ack with done", 1, 3'd4, 16'h0000, 1, 2'd2, 1);
        rd("R12 status", 3'd3);
        step("R12 ack", 1, 3'd4, 16'h0000);
        // R5/R6/R10: polarity, ready, readback
        step("R6 cfg low", 1, 3'd1, 16'h001F);
        rd("R10 cfg readback", 3'd1);
        step("R5 active low done", 0, 3'd1, 16'h0, 1, 2'd1, 0);
        step("R5 active low ack", 1, 3'd4, 16'h0000);
        step("R6 cfg high", 1, 3'd1, 16'hFFFF);
        rd("R10 cfg all ones", 3'd1);
        // R13: unused select and status writes ignored
        step("R13 write sel7", 1, 3'd7, 16'hFFFF);
        step("R13 write status", 1, 3'd3, 16'hFFFF);
        rd("R13 status intact", 3'd3);
        step("R2 cfg2 set", 1, 3'd2, 16'hA5A5);
        // R2: warm reset opcode with simultaneous done
        step("R2 warm reset", 1, 3'd0, 16'h00F3, 1, 2'd0, 1);
        for (int s = 0; s < 5; s++) rd("R2 warm values", 3'(s));
        step("R2 ack", 1, 3'd4, 16'h0000);
        step("R2 warm F0", 1, 3'd0, 16'h00F0);
        rd("R2 warm int", 3'd4);

        // Seeded random traffic
        for (int i = 0; i < 3000; i++) begin
            bit wr = ($urandom % 2) == 1;
            logic [2:0] sel = 3'($urandom % 6);
            logic [15:0] d = 16'($urandom);
            bit dn = ($urandom % 5) == 0;
            if (sel == 3'd0) begin
                case ($urandom % 4)
                    0: d[7:0] = 8'h00;
                    1: d[7:0] = 8'h94;
                    2: d[7:0] = (($urandom % 8) == 0) ? 8'hF0 : 8'h1B;
                    default: ;
                endcase
            end
            if (sel == 3'd4 && ($urandom % 2) == 0) d = 16'h0000;
            step("R7 R8 R4 random", wr, sel, d, dn, 2'($urandom % 4), ($urandom % 3) == 0);
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule